// File: doc/BRIEF.md
# Match Capture Timer With PWM

This block is a 32-bit counting unit for a peripheral subsystem. A prescaler divides the counting clock, and the counter advances once every PRESCALE+1 counting-clock cycles. The counting clock is either the system clock or edges on one of the capture inputs. Four compare channels watch the counter. When the counter sits at a channel's compare value during a counting step, the channel can do any of the following:
- raise an interrupt flag;
- send the counter back to zero;
- freeze the counter and clear the enable bit;
- change its output pin.

Each capture input passes through a two-flop synchronizer. On a selected edge, it copies the counter into its own capture register.

In PWM mode, compare channels 0 to 2 drive single-edge pulse-width outputs, and channel 3 sets the period. Software reaches the block through a plain word-addressed register port. A write takes effect on the clock edge where `bus_wen` is high. Reads are combinational from `bus_addr`. The port has no handshake and never stalls. Every pin on this block is plain control or status, so no valid/ready interface is used.

Top module: `mct_timer`

## Requirements
- R1: After reset, every register reads zero, `match_o` is 0000 and `irq_o` is low.
- R2: With CTRL bit0 set and PRESCALE (0x0C) holding p, the counter rises by one every p+1 counting clocks.
- R3: CTRL (0x04) bit0 enables counting. CTRL bit1 holds the counter at zero and overrides both counting and COUNT writes. A disabled counter keeps its value.
- R4: MCTRL (0x10) gives channel i three bits: irq at bit 3i, reset at 3i+1 and stop at 3i+2. With the irq bit set, INTF bit i sets when a counting step happens while COUNT equals MATCHi (0x14+4i). `irq_o` is high while any INTF bit is set.
- R5: With the reset bit of a channel set, the value after a matching step is zero, so one period is MATCH+1 steps.
- R6: With the stop bit of a channel set, the counter stays at the match value after the matching step and CTRL bit0 clears.
- R7: EXT (0x38) bits 3:0 are the output states. The 2-bit code at bits 4+2i sets what a match does to output i: 0 leaves it unchanged, 1 drives it low, 2 drives it high, 3 toggles it. `match_o` shows the state bits of channels that are not in PWM mode.
- R8: CAPCTRL (0x24) gives capture input j three bits: rise at 3j, fall at 3j+1 and irq at 3j+2. On an enabled edge, CAPj (0x28+4j) loads COUNT. With the irq bit set, INTF bit 4+j also sets. A disabled edge leaves CAPj unchanged.
- R9: INTF (0x00) is write-one-to-clear. Writing 0 to a bit has no effect, and a new event in the same cycle as a clear wins.
- R10: CLKSRC (0x40) bit0=1 makes the counting clock the edges of the capture input picked by bits 2:1. Bits 4:3 pick the edge: 1 selects rising, 2 selects falling, 3 selects both. The prescaler still applies.
- R11: PWMCTRL (0x3C) bit i (i<3) puts output i in PWM mode. The output is low from the start of each period and high once COUNT reaches MATCHi; MATCHi=0 gives high for the whole period. While any PWM bit is set, channel 3 resets the counter.
- R12: A write to COUNT (0x08) loads the value and restarts the prescale count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register byte address |
| bus_wen | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | TW | Write data |
| bus_rdata | output | TW | Read data for `bus_addr` |
| cap_i | input | NCAP | Asynchronous capture inputs |
| match_o | output | 4 | Match / PWM outputs |
| irq_o | output | 1 | Interrupt, high while any flag is pending |

## Verification
The prescaler is run with a divide-by-three setting, so an off-by-one in the compare of the prescale count shows up as a wrong count. Matches are exercised in several ways:
- A reset-on-match loop stopped after a step count that is not a multiple of the period, which separates a period of MATCH+1 from a period of MATCH.
- A stop-on-match case.
- One simultaneous match across all four channels, with each channel set to a different action code, so every code shows in a single output vector.

Capture is driven with an enabled and a disabled edge on each of two inputs, which separates edge selection from level sensing. External pulses are counted first on rising edges only and then on both edges. PWM outputs are sampled every cycle against the live count, with a zero, a mid and an out-of-range compare value.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int NMATCH = 4;

  localparam int OFF_INTF    = 'h00;
  localparam int OFF_CTRL    = 'h04;
  localparam int OFF_COUNT   = 'h08;
  localparam int OFF_PRESC   = 'h0C;
  localparam int OFF_MCTRL   = 'h10;
  localparam int OFF_MATCH   = 'h14;
  localparam int OFF_CAPCTRL = 'h24;
  localparam int OFF_CAP     = 'h28;
  localparam int OFF_EXT     = 'h38;
  localparam int OFF_PWM     = 'h3C;
  localparam int OFF_CLKSRC  = 'h40;

  typedef enum logic [1:0] {
    EM_NONE   = 2'd0,
    EM_LOW    = 2'd1,
    EM_HIGH   = 2'd2,
    EM_TOGGLE = 2'd3
  } em_act_e;
endpackage

// File: rtl/mct_edge.sv
module mct_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  // two synchronizer flops plus one history flop
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], din};
  end

  assign rise_o = sh[1] & ~sh[2];
  assign fall_o = ~sh[1] & sh[2];
endmodule

// File: rtl/mct_count.sv
module mct_count #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  logic          tick,
  input  logic          load_en,
  input  logic [TW-1:0] load_val,
  input  logic [TW-1:0] pr,
  input  logic          wrap,
  input  logic          stop,
  output logic [TW-1:0] tc,
  output logic          step
);
  logic [TW-1:0] pc;

  assign step = run & tick & ~hold & ~load_en & (pc == pr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= '0;
      pc <= '0;
    end else if (hold) begin
      tc <= '0;
      pc <= '0;
    end else if (load_en) begin
      tc <= load_val;
      pc <= '0;
    end else if (run && tick) begin
      if (pc == pr) begin
        pc <= '0;
        if (wrap)       tc <= '0;
        else if (!stop) tc <= tc + 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int TW   = 32,
  parameter int NCAP = 4,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wen,
  input  logic [TW-1:0]   bus_wdata,
  output logic [TW-1:0]   bus_rdata,
  input  logic [NCAP-1:0] cap_i,
  output logic [3:0]      match_o,
  output logic            irq_o
);
  localparam int SELW  = (NCAP > 1) ? $clog2(NCAP) : 1;
  localparam int NFLAG = NMATCH + NCAP;
  localparam logic [AW-1:0] A_INTF    = AW'(OFF_INTF);
  localparam logic [AW-1:0] A_CTRL    = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_COUNT   = AW'(OFF_COUNT);
  localparam logic [AW-1:0] A_PRESC   = AW'(OFF_PRESC);
  localparam logic [AW-1:0] A_MCTRL   = AW'(OFF_MCTRL);
  localparam logic [AW-1:0] A_CAPCTRL = AW'(OFF_CAPCTRL);
  localparam logic [AW-1:0] A_EXT     = AW'(OFF_EXT);
  localparam logic [AW-1:0] A_PWM     = AW'(OFF_PWM);
  localparam logic [AW-1:0] A_CLKSRC  = AW'(OFF_CLKSRC);

  logic                  ctrl_en, ctrl_hold;
  logic [TW-1:0]         pr;
  logic [3*NMATCH-1:0]   mctrl;
  logic [TW-1:0]         mr [NMATCH];
  logic [3*NCAP-1:0]     capctrl;
  logic [TW-1:0]         capv [NCAP];
  logic [NMATCH-1:0]     ext_state;
  logic [2*NMATCH-1:0]   ext_act;
  logic [2:0]            pwm_en;
  logic                  src_cnt;
  logic [SELW-1:0]       src_sel;
  logic [1:0]            src_edge;
  logic [NFLAG-1:0]      flags;

  logic [TW-1:0]         tc;
  logic                  step, tick, wrap_any, stop_any, load_en;
  logic [NMATCH-1:0]     hit, m_wrap, m_stop;
  logic [NCAP-1:0]       c_rise, c_fall, cap_evt, cap_set;

  assign load_en = bus_wen && bus_addr == A_COUNT;

  // counting clock: every cycle, or selected edges of one capture input
  assign tick = src_cnt ? ((src_edge[0] & c_rise[src_sel]) | (src_edge[1] & c_fall[src_sel]))
                        : 1'b1;

  mct_count #(.TW(TW)) u_count (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .hold(ctrl_hold), .tick(tick),
    .load_en(load_en), .load_val(bus_wdata), .pr(pr),
    .wrap(wrap_any), .stop(stop_any), .tc(tc), .step(step)
  );

  // compare channels
  for (genvar i = 0; i < NMATCH; i++) begin : g_match
    assign hit[i]    = step && (tc == mr[i]);
    assign m_wrap[i] = hit[i] & (mctrl[3*i+1] | ((i == NMATCH-1) & (|pwm_en)));
    assign m_stop[i] = hit[i] & mctrl[3*i+2];
    if (i < 3) begin : g_pwm
      assign match_o[i] = pwm_en[i] ? (tc >= mr[i]) : ext_state[i];
    end else begin : g_plain
      assign match_o[i] = ext_state[i];
    end
  end
  assign wrap_any = |m_wrap;
  assign stop_any = |m_stop;

  // capture channels
  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    mct_edge u_edge (
      .clk(clk), .rst_n(rst_n), .din(cap_i[j]),
      .rise_o(c_rise[j]), .fall_o(c_fall[j])
    );
    assign cap_evt[j] = (capctrl[3*j] & c_rise[j]) | (capctrl[3*j+1] & c_fall[j]);
    assign cap_set[j] = cap_evt[j] & capctrl[3*j+2];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          capv[j] <= '0;
      else if (cap_evt[j]) capv[j] <= tc;
    end
  end

  // register writes and match-driven updates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_hold <= 1'b0;
      pr        <= '0;
      mctrl     <= '0;
      capctrl   <= '0;
      ext_state <= '0;
      ext_act   <= '0;
      pwm_en    <= '0;
      src_cnt   <= 1'b0;
      src_sel   <= '0;
      src_edge  <= '0;
      flags     <= '0;
      for (int i = 0; i < NMATCH; i++) mr[i] <= '0;
    end else begin
      if (bus_wen) begin
        if (bus_addr == A_CTRL) begin
          ctrl_en   <= bus_wdata[0];
          ctrl_hold <= bus_wdata[1];
        end
        if (bus_addr == A_PRESC)   pr      <= bus_wdata;
        if (bus_addr == A_MCTRL)   mctrl   <= bus_wdata[3*NMATCH-1:0];
        if (bus_addr == A_CAPCTRL) capctrl <= bus_wdata[3*NCAP-1:0];
        if (bus_addr == A_PWM)     pwm_en  <= bus_wdata[2:0];
        if (bus_addr == A_EXT) begin
          ext_state <= bus_wdata[NMATCH-1:0];
          ext_act   <= bus_wdata[NMATCH +: 2*NMATCH];
        end
        if (bus_addr == A_CLKSRC) begin
          src_cnt  <= bus_wdata[0];
          src_sel  <= bus_wdata[SELW:1];
          src_edge <= bus_wdata[SELW+2:SELW+1];
        end
        for (int i = 0; i < NMATCH; i++)
          if (bus_addr == AW'(OFF_MATCH + 4*i)) mr[i] <= bus_wdata;
      end
      if (stop_any) ctrl_en <= 1'b0;
      for (int i = 0; i < NMATCH; i++) begin
        if (hit[i]) begin
          case (em_act_e'(ext_act[2*i +: 2]))
            EM_LOW:    ext_state[i] <= 1'b0;
            EM_HIGH:   ext_state[i] <= 1'b1;
            EM_TOGGLE: ext_state[i] <= ~ext_state[i];
            default:   ;
          endcase
        end
      end
      flags <= (flags & ~((bus_wen && bus_addr == A_INTF) ? bus_wdata[NFLAG-1:0] : '0))
             | {cap_set, hit & {mctrl[9], mctrl[6], mctrl[3], mctrl[0]}};
    end
  end

  assign irq_o = |flags;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_INTF)    bus_rdata = TW'(flags);
    if (bus_addr == A_CTRL)    bus_rdata = TW'({ctrl_hold, ctrl_en});
    if (bus_addr == A_COUNT)   bus_rdata = tc;
    if (bus_addr == A_PRESC)   bus_rdata = pr;
    if (bus_addr == A_MCTRL)   bus_rdata = TW'(mctrl);
    if (bus_addr == A_CAPCTRL) bus_rdata = TW'(capctrl);
    if (bus_addr == A_EXT)     bus_rdata = TW'({ext_act, ext_state});
    if (bus_addr == A_PWM)     bus_rdata = TW'(pwm_en);
    if (bus_addr == A_CLKSRC)  bus_rdata = TW'({src_edge, src_sel, src_cnt});
    for (int i = 0; i < NMATCH; i++)
      if (bus_addr == AW'(OFF_MATCH + 4*i)) bus_rdata = mr[i];
    for (int j = 0; j < NCAP; j++)
      if (bus_addr == AW'(OFF_CAP + 4*j)) bus_rdata = capv[j];
  end
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
  parameter int TW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wen,
  input logic [TW-1:0] tc,
  input logic          ctrl_en,
  input logic          ctrl_hold,
  input logic          irq_o,
  input logic          cap_evt0,
  input logic [TW-1:0] cap0
);
  logic wr_count, wr_intf;
  assign wr_count = bus_wen && bus_addr == AW'(mct_pkg::OFF_COUNT);
  assign wr_intf  = bus_wen && bus_addr == AW'(mct_pkg::OFF_INTF);

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hold |=> tc == '0);

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !ctrl_hold && !wr_count) |=> $stable(tc));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_count |=> (tc == $past(tc) || tc == $past(tc) + 1'b1 || tc == '0));

  assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt0 |=> cap0 == $past(tc));

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(wr_intf));
endmodule

bind mct_timer mct_timer_chk #(.TW(TW), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .tc(tc), .ctrl_en(ctrl_en), .ctrl_hold(ctrl_hold), .irq_o(irq_o),
  .cap_evt0(cap_evt[0]), .cap0(capv[0])
);

// File: tb/test_mct_timer.sv
module test_mct_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cap_i = '0;
  logic [3:0]  match_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mct_timer i_mct_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_i(cap_i),
    .match_o(match_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 INTF", 8'h00, 0);
    expect_reg("R1 CTRL", 8'h04, 0);
    expect_reg("R1 COUNT", 8'h08, 0);
    expect_reg("R1 PRESC", 8'h0C, 0);
    expect_reg("R1 MCTRL", 8'h10, 0);
    expect_reg("R1 MATCH0", 8'h14, 0);
    expect_reg("R1 CAP0", 8'h28, 0);
    expect_reg("R1 EXT", 8'h38, 0);
    expect_reg("R1 PWM", 8'h3C, 0);
    expect_reg("R1 CLKSRC", 8'h40, 0);
    check("R1 match_o", {28'd0, match_o}, 0);
    check("R1 irq_o", {31'd0, irq_o}, 0);
  endtask

  task automatic t_prescale_load;
    wr(8'h08, 32'd5);
    repeat (10) @(negedge clk);
    expect_reg("R12 load / R3 disabled holds", 8'h08, 5);
    wr(8'h0C, 32'd2);
    wr(8'h08, 32'd0);
    wr(8'h04, 32'd1);
    repeat (29) @(negedge clk);
    wr(8'h04, 32'd0);
    expect_reg("R2 prescale 2, 30 clocks", 8'h08, 10);
    wr(8'h0C, 32'd0);
  endtask

  task automatic t_hold;
    wr(8'h08, 32'd9);
    wr(8'h04, 32'd3);
    repeat (3) @(negedge clk);
    expect_reg("R3 hold clears", 8'h08, 0);
    wr(8'h08, 32'd7);
    expect_reg("R3 hold blocks write", 8'h08, 0);
    wr(8'h04, 32'd0);
  endtask

  task automatic t_match_irq;
    wr(8'h10, 32'h3);
    wr(8'h14, 32'd4);
    wr(8'h08, 32'd0);
    wr(8'h04, 32'd1);
    repeat (12) @(negedge clk);
    wr(8'h04, 32'd0);
    expect_reg("R5 period MATCH+1, 13 steps", 8'h08, 3);
    expect_reg("R4 flag ch0", 8'h00, 1);
    check("R4 irq_o high", {31'd0, irq_o}, 1);
    wr(8'h00, 32'h0);
    expect_reg("R9 write zero keeps flag", 8'h00, 1);
    wr(8'h00, 32'h1);
    expect_reg("R9 write one clears", 8'h00, 0);
    check("R9 irq_o low", {31'd0, irq_o}, 0);
  endtask

  task automatic t_stop;
    wr(8'h10, 32'h20);
    wr(8'h18, 32'd6);
    wr(8'h08, 32'd0);
    wr(8'h04, 32'd1);
    repeat (20) @(negedge clk);
    expect_reg("R6 stopped at match", 8'h08, 6);
    expect_reg("R6 enable cleared", 8'h04, 0);
  endtask

  task automatic t_ext;
    wr(8'h10, 32'h2);
    for (int i = 0; i < 4; i++) wr(8'h14 + 8'(4*i), 32'd3);
    wr(8'h38, 32'h1BC);
    wr(8'h08, 32'd0);
    wr(8'h04, 32'd1);
    repeat (5) @(negedge clk);
    wr(8'h04, 32'd0);
    check("R7 toggle/high/low/none", {28'd0, match_o}, 32'hB);
    expect_reg("R7 EXT readback", 8'h38, 32'h1BB);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_capture;
    wr(8'h00, 32'hFF);
    wr(8'h24, 32'h15);
    wr(8'h08, 32'h1234);
    cap_i[0] = 1'b1;
    repeat (4) @(negedge clk);
    expect_reg("R8 rising capture", 8'h28, 32'h1234);
    expect_reg("R8 capture flag", 8'h00, 32'h10);
    wr(8'h08, 32'h55);
    cap_i[0] = 1'b0;
    repeat (4) @(negedge clk);
    expect_reg("R8 falling ignored on rise-only", 8'h28, 32'h1234);
    cap_i[1] = 1'b1;
    repeat (4) @(negedge clk);
    expect_reg("R8 rising ignored on fall-only", 8'h2C, 0);
    wr(8'h08, 32'h77);
    cap_i[1] = 1'b0;
    repeat (4) @(negedge clk);
    expect_reg("R8 falling capture", 8'h2C, 32'h77);
    expect_reg("R8 no flag without irq bit", 8'h00, 32'h10);
    wr(8'h00, 32'hFF);
    wr(8'h24, 32'h0);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      cap_i[2] = 1'b1;
      repeat (3) @(negedge clk);
      cap_i[2] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_count_mode;
    wr(8'h40, 32'hD);
    wr(8'h0C, 32'd1);
    wr(8'h08, 32'd0);
    wr(8'h04, 32'd1);
    pulses(8);
    wr(8'h04, 32'd0);
    expect_reg("R10 rising edges, prescale 1", 8'h08, 4);
    wr(8'h40, 32'h1D);
    wr(8'h0C, 32'd0);
    wr(8'h08, 32'd0);
    wr(8'h04, 32'd1);
    pulses(3);
    wr(8'h04, 32'd0);
    expect_reg("R10 both edges", 8'h08, 6);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_pwm;
    logic [31:0] tcv;
    int top = 0;
    wr(8'h14, 32'd0);
    wr(8'h18, 32'd4);
    wr(8'h1C, 32'd20);
    wr(8'h20, 32'd9);
    wr(8'h3C, 32'h7);
    wr(8'h08, 32'd0);
    wr(8'h04, 32'd1);
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      rd(8'h08, tcv);
      if (tcv > top) top = tcv;
      check("R11 period bound", {31'd0, tcv > 9}, 0);
      check("R11 pwm outputs", {29'd0, match_o[2:0]}, {29'd0, 1'b0, tcv >= 4, 1'b1});
    end
    check("R11 period top reached", top, 9);
    wr(8'h04, 32'd0);
    wr(8'h3C, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale_load();
    t_hold();
    t_match_irq();
    t_stop();
    t_ext();
    t_capture();
    t_count_mode();
    t_pwm();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule